// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block turns a single burst request into the stream of column addresses that a synchronous DRAM controller places on the bus, one address per clock. A request carries a starting column and a four-bit mode word. The low three bits of the mode word pick the burst length and bit 3 picks the ordering. Finite bursts of 1, 2, 4 or 8 beats stay inside an aligned block of columns and wrap within it. The order is either an upward count or a count XORed with the starting offset. A full-page burst walks every column of the page, wraps from the top column back to column 0, and runs until it is told to stop.

Every output beat carries a valid flag, and the natural end of a finite burst is marked with a last flag. Bad requests raise a one-cycle error pulse and produce no beats. These are reserved length codes, and a full-page length combined with the XOR ordering. A new burst may follow the final beat of the previous one without a gap.

Top module: `burst_col_seq`

## Requirements
- R1: The mode word is decoded as follows. Bits [2:0] give the length: 3'b000 gives 1 beat, 3'b001 gives 2, 3'b010 gives 4, 3'b011 gives 8 and 3'b111 gives a full page. Bit 3 gives the ordering: 0 for upward count, 1 for XOR order.
- R2: The first beat appears in the cycle after the start is accepted. A finite burst keeps `valid_o` high for exactly its length in cycles, and `last_o` is high only on its final beat.
- R3: In a finite burst of length L, the column bits above the low log2(L) bits equal those of the starting column on every beat.
- R4: In upward-count order, the low bits start at the starting offset, rise by one each beat and wrap modulo L (length 4 from offset 2 gives 2,3,0,1).
- R5: In XOR order, beat k carries low bits equal to the starting offset XOR k (length 8 from offset 5 gives 5,4,7,6,1,0,3,2).
- R6: A full-page burst adds one to the column on each beat and wraps from 2^COL_W-1 to 0. It never raises `last_o` and continues until terminated.
- R7: A full-page length with XOR order raises `err_o` for one cycle, in the cycle after the request, and issues no beat.
- R8: Length codes 3'b100, 3'b101 and 3'b110 are reserved. They raise `err_o` for one cycle, in the cycle after the request, and issue no beat.
- R9: When `term_i` is high during a beat, that beat is the last one shown and `valid_o` is low in the next cycle. `term_i` has no effect while idle.
- R10: A start is accepted only while idle or during a beat with `last_o` high. A start during any other beat is ignored and the running burst continues unchanged.
- R11: A length-1 burst emits the starting column unchanged as one beat with `last_o` high.
- R12: While reset is asserted and after it is released, `valid_o`, `last_o` and `err_o` are low until a request arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Burst request |
| start_col_i | input | COL_W | Starting column of the request |
| mode_i | input | 4 | Mode word: [2:0] length code, [3] ordering |
| term_i | input | 1 | Terminate the running burst after the current beat |
| col_o | output | COL_W | Column address of the current beat (zero when idle) |
| valid_o | output | 1 | A beat is present on col_o |
| last_o | output | 1 | Final beat of a finite burst |
| err_o | output | 1 | One-cycle pulse for a rejected request |

## Verification
Every result lags its cause by exactly one register stage. A request sampled at a clock edge yields its first beat or its error pulse in the following cycle. A terminate or a final beat sampled at an edge clears `valid_o` in the following cycle. The bench holds a behavioural model that advances on the same rising edge as the design and builds each expected burst as a queue of columns. It compares valid, column, last and error on every falling edge, half a period after that edge, so each result is checked in the one cycle it is due. Stimuli are driven on falling edges, so the timing of every request relative to the last beat is decided by the model rather than by the script.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

  localparam int MODE_W = 4;
  localparam int ORDER_BIT = 3;

  typedef enum logic [2:0] {
    LEN_ONE   = 3'b000,
    LEN_TWO   = 3'b001,
    LEN_FOUR  = 3'b010,
    LEN_EIGHT = 3'b011,
    LEN_RSV4  = 3'b100,
    LEN_RSV5  = 3'b101,
    LEN_RSV6  = 3'b110,
    LEN_PAGE  = 3'b111
  } len_code_e;

  typedef enum logic {
    ORD_COUNT = 1'b0,
    ORD_XOR   = 1'b1
  } order_e;

endpackage

// File: rtl/bcs_len_decode.sv
module bcs_len_decode
  import bcs_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic [MODE_W-1:0] mode_i,
  output logic [COL_W-1:0]  mask_o,
  output logic              full_o,
  output logic              xor_o,
  output logic              bad_o
);

  len_code_e code;
  logic      rsv;

  assign code  = len_code_e'(mode_i[2:0]);
  assign xor_o = (order_e'(mode_i[ORDER_BIT]) == ORD_XOR);

  always_comb begin
    mask_o = '0;
    full_o = 1'b0;
    rsv    = 1'b0;
    case (code)
      LEN_ONE, LEN_TWO, LEN_FOUR, LEN_EIGHT:
        mask_o = COL_W'((32'd1 << mode_i[1:0]) - 32'd1);
      LEN_PAGE: begin
        mask_o = '1;
        full_o = 1'b1;
      end
      default: rsv = 1'b1;
    endcase
  end

  assign bad_o = rsv | (full_o & xor_o);

endmodule

// File: rtl/bcs_addr_gen.sv
module bcs_addr_gen #(
  parameter int COL_W = 8
) (
  input  logic [COL_W-1:0] base_i,
  input  logic [COL_W-1:0] beat_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             xor_i,
  output logic [COL_W-1:0] col_o
);

  logic [COL_W-1:0] cnt_sum;
  logic [COL_W-1:0] xor_mix;

  assign cnt_sum = base_i + beat_i;
  assign xor_mix = base_i ^ beat_i;

  for (genvar b = 0; b < COL_W; b++) begin : g_bit
    logic low_bit;
    assign low_bit  = xor_i ? xor_mix[b] : cnt_sum[b];
    assign col_o[b] = mask_i[b] ? low_bit : base_i[b];
  end

endmodule

// File: rtl/bcs_ctrl.sv
module bcs_ctrl
  import bcs_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic             term_i,
  input  logic [COL_W-1:0] dec_mask_i,
  input  logic             dec_full_i,
  input  logic             dec_xor_i,
  input  logic             dec_bad_i,
  output logic             busy_o,
  output logic             last_o,
  output logic             err_o,
  output logic [COL_W-1:0] base_o,
  output logic [COL_W-1:0] beat_o,
  output logic [COL_W-1:0] mask_o,
  output logic             full_o,
  output logic             xor_o
);

  logic             busy_q, busy_d;
  logic             err_q, err_d;
  logic             full_q, full_d;
  logic             xor_q, xor_d;
  logic [COL_W-1:0] base_q, base_d;
  logic [COL_W-1:0] beat_q, beat_d;
  logic [COL_W-1:0] mask_q, mask_d;
  logic             at_last;
  logic             accept;
  logic             load_en;
  logic             beat_en;

  assign at_last = busy_q & ~full_q & (beat_q == mask_q);
  assign accept  = start_i & (~busy_q | at_last);
  assign load_en = accept & ~dec_bad_i;
  assign beat_en = busy_q & ~term_i & ~at_last & ~accept;

  always_comb begin
    busy_d = busy_q;
    err_d  = 1'b0;
    base_d = base_q;
    beat_d = beat_q;
    mask_d = mask_q;
    full_d = full_q;
    xor_d  = xor_q;
    if (busy_q && (term_i || at_last)) begin
      busy_d = 1'b0;
    end
    if (accept) begin
      err_d = dec_bad_i;
    end
    if (load_en) begin
      busy_d = 1'b1;
      base_d = start_col_i;
      beat_d = '0;
      mask_d = dec_mask_i;
      full_d = dec_full_i;
      xor_d  = dec_xor_i;
    end else if (beat_en) begin
      beat_d = beat_q + COL_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      busy_q <= busy_d;
      err_q  <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      beat_q <= '0;
      mask_q <= '0;
      full_q <= 1'b0;
      xor_q  <= 1'b0;
    end else if (load_en || beat_en) begin
      base_q <= base_d;
      beat_q <= beat_d;
      mask_q <= mask_d;
      full_q <= full_d;
      xor_q  <= xor_d;
    end
  end

  assign busy_o = busy_q;
  assign last_o = at_last;
  assign err_o  = err_q;
  assign base_o = base_q;
  assign beat_o = beat_q;
  assign mask_o = mask_q;
  assign full_o = full_q;
  assign xor_o  = xor_q;

endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import bcs_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [3:0]       mode_i,
  input  logic             term_i,
  output logic [COL_W-1:0] col_o,
  output logic             valid_o,
  output logic             last_o,
  output logic             err_o
);

  logic [COL_W-1:0] dec_mask;
  logic             dec_full;
  logic             dec_xor;
  logic             dec_bad;
  logic             busy;
  logic [COL_W-1:0] base_q;
  logic [COL_W-1:0] beat_q;
  logic [COL_W-1:0] mask_q;
  logic             full_q;
  logic             xor_q;
  logic [COL_W-1:0] gen_col;

  bcs_len_decode #(.COL_W(COL_W)) u_dec (
    .mode_i (mode_i),
    .mask_o (dec_mask),
    .full_o (dec_full),
    .xor_o  (dec_xor),
    .bad_o  (dec_bad)
  );

  bcs_ctrl #(.COL_W(COL_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .start_col_i (start_col_i),
    .term_i      (term_i),
    .dec_mask_i  (dec_mask),
    .dec_full_i  (dec_full),
    .dec_xor_i   (dec_xor),
    .dec_bad_i   (dec_bad),
    .busy_o      (busy),
    .last_o      (last_o),
    .err_o       (err_o),
    .base_o      (base_q),
    .beat_o      (beat_q),
    .mask_o      (mask_q),
    .full_o      (full_q),
    .xor_o       (xor_q)
  );

  bcs_addr_gen #(.COL_W(COL_W)) u_gen (
    .base_i (base_q),
    .beat_i (beat_q),
    .mask_i (mask_q),
    .xor_i  (xor_q),
    .col_o  (gen_col)
  );

  assign valid_o = busy;
  assign col_o   = busy ? gen_col : '0;

endmodule

// File: rtl/bcs_checker.sv
module bcs_checker #(
  parameter int COL_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             term_i,
  input logic [COL_W-1:0] col_o,
  input logic             valid_o,
  input logic             last_o,
  input logic             err_o,
  input logic [COL_W-1:0] mask_q,
  input logic             full_q,
  input logic             xor_q
);

  assert_last_needs_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |-> valid_o);

  assert_burst_continues_R2: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o && !last_o && !term_i |=> valid_o);

  assert_end_after_final_R9: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o && (last_o || term_i) && !start_i |=> !valid_o);

  assert_block_fixed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o && !last_o && !term_i && !full_q |=>
      ((col_o & ~mask_q) == ($past(col_o) & ~$past(mask_q))));

  assert_count_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o && !last_o && !term_i && !xor_q |=>
      ((col_o & mask_q) == (($past(col_o) + COL_W'(1)) & $past(mask_q))));

  assert_page_no_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
    full_q && valid_o |-> !last_o);

  assert_err_no_beat_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> !valid_o);

  assert_err_from_request_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> $past(start_i));

endmodule

bind burst_col_seq bcs_checker #(.COL_W(COL_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start_i (start_i),
  .term_i  (term_i),
  .col_o   (col_o),
  .valid_o (valid_o),
  .last_o  (last_o),
  .err_o   (err_o),
  .mask_q  (mask_q),
  .full_q  (full_q),
  .xor_q   (xor_q)
);

// File: tb/burst_col_seq_tb.sv
module burst_col_seq_tb;

  localparam int COL_W = 8;
  localparam int PAGE  = 1 << COL_W;

  logic             clk;
  logic             rst_n;
  logic             start_i;
  logic [COL_W-1:0] start_col_i;
  logic [3:0]       mode_i;
  logic             term_i;
  logic [COL_W-1:0] col_o;
  logic             valid_o;
  logic             last_o;
  logic             err_o;

  burst_col_seq #(.COL_W(COL_W)) u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .start_col_i (start_col_i),
    .mode_i      (mode_i),
    .term_i      (term_i),
    .col_o       (col_o),
    .valid_o     (valid_o),
    .last_o      (last_o),
    .err_o       (err_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int    total = 0;
  int    bad   = 0;
  int    cycles = 0;
  bit    done  = 0;

  int    exp_q[$];
  bit    pg_on = 0;
  int    pg_col = 0;
  bit    m_err = 0;
  string tag = "R2";

  task automatic check(input string req, input int act, input int expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h at cycle %0d", req, act, expv, cycles);
    end
  endtask

  // reference model: updates on the same edge as the design
  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      exp_q.delete();
      pg_on = 0;
      m_err = 0;
    end else begin
      bit cv, cl, acc;
      cv  = pg_on || (exp_q.size() > 0);
      cl  = !pg_on && (exp_q.size() == 1);
      acc = start_i && (!cv || cl);
      if (cv) begin
        if (term_i || cl) begin
          exp_q.delete();
          pg_on = 0;
        end else if (pg_on) begin
          pg_col = (pg_col + 1) % PAGE;
        end else begin
          void'(exp_q.pop_front());
        end
      end
      m_err = 0;
      if (acc) begin
        int  code, len, s, off;
        bit  ix;
        code = int'(mode_i[2:0]);
        ix   = mode_i[3];
        if (code > 3 && code != 7) begin
          m_err = 1;
        end else if (code == 7) begin
          if (ix) m_err = 1;
          else begin
            pg_on  = 1;
            pg_col = int'(start_col_i);
            tag    = "R6";
          end
        end else begin
          len = 1 << code;
          s   = int'(start_col_i);
          off = s % len;
          for (int k = 0; k < len; k++) begin
            int lo;
            lo = ix ? (off ^ k) : ((off + k) % len);
            exp_q.push_back(s - off + lo);
          end
          tag = (len == 1) ? "R11" : (ix ? "R5" : "R4");
        end
      end
    end
  end

  // comparison half a period after each edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit ev, el;
      int ec;
      ev = pg_on || (exp_q.size() > 0);
      el = !pg_on && (exp_q.size() == 1);
      ec = pg_on ? pg_col : (ev ? exp_q[0] : 0);
      check("R2 valid", int'(valid_o), int'(ev));
      check("R2 last", int'(last_o), int'(el));
      check("R7 R8 err", int'(err_o), int'(m_err));
      if (ev) check({tag, " R3 column"}, int'(col_o), ec);
    end
  end

  task automatic go(input int col, input int mode);
    @(negedge clk);
    start_i     = 1'b1;
    start_col_i = COL_W'(col);
    mode_i      = 4'(mode);
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic stop_burst();
    @(negedge clk);
    term_i = 1'b1;
    @(negedge clk);
    term_i = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    wait (cycles > 100000);
    total++;
    bad++;
    $display("FAIL watchdog: actual=%0d expected<100000 cycles", cycles);
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    start_i = 1'b0;
    start_col_i = '0;
    mode_i = '0;
    term_i = 1'b0;
    wait_n(3);
    // R12: outputs quiet in reset
    check("R12 valid", int'(valid_o), 0);
    check("R12 last", int'(last_o), 0);
    check("R12 err", int'(err_o), 0);
    @(negedge clk);
    rst_n = 1'b1;
    wait_n(2);
    check("R12 idle valid", int'(valid_o), 0);

    go(8'h3B, 4'b0000); wait_n(3);   // R11 length 1
    go(8'h57, 4'b0001); wait_n(4);   // R4 length 2 wrap
    go(8'h56, 4'b0010); wait_n(5);   // R4 length 4 from 2
    go(8'hC5, 4'b0011); wait_n(9);   // R4 length 8
    go(8'h25, 4'b1011); wait_n(9);   // R5 length 8 from 5
    go(8'h93, 4'b1010); wait_n(5);   // R5 length 4
    go(8'h41, 4'b1001); wait_n(3);   // R5 length 2
    go(8'hFF, 4'b1000); wait_n(3);   // R1 length 1, XOR order
    go(8'hF0, 4'b1111); wait_n(3);   // R7 page + XOR rejected
    go(8'h10, 4'b0100); wait_n(2);   // R8 reserved
    go(8'h10, 4'b0101); wait_n(2);   // R8 reserved
    go(8'h10, 4'b1110); wait_n(2);   // R8 reserved
    stop_burst(); wait_n(2);         // R9 terminate while idle
    go(8'hFA, 4'b0111); wait_n(265); // R6 page wraps past 0
    stop_burst(); wait_n(3);         // R9 ends page burst
    go(8'h68, 4'b0011); wait_n(2);   // R10 start mid-burst ignored
    go(8'h00, 4'b0001); wait_n(8);
    go(8'h84, 4'b0010); wait_n(1);   // R9 terminate finite burst
    stop_burst(); wait_n(4);
    go(8'h31, 4'b0010); wait_n(2);   // R10 back-to-back on last beat
    go(8'h77, 4'b1010);
    wait_n(1);
    go(8'hA9, 4'b0100); wait_n(8);   // R8 rejected on last beat
    go(8'h0E, 4'b0001); wait_n(1);   // R10 chained again
    go(8'hEE, 4'b0000); wait_n(4);
    finish_run();
  end

endmodule